// File: doc/BRIEF.md
# Indirect Extended Register Sequencer

This block reaches a 16-bit extended register space that lies behind a small window of byte-wide standard registers. A window of four standard registers does the work. One holds the extended byte value, two hold the upper and lower halves of the extended address, and one is a control register that starts an access and reads back zero once the access has finished. A client hands the block one command: an extended read, an extended write, or a sensitivity update. The block then issues the matching series of standard register accesses on a request/acknowledge port. The transport that carries those accesses to the device is not part of this block.

After it writes the control register, the block polls that register. The polls are separated by a programmable number of idle cycles, and there is a fixed maximum number of them. The command ends with a single done pulse and a result code: success, bus error or timeout. For a read or a sensitivity update the byte result comes with it. The sensitivity update is a read-modify-write of the configuration byte at extended address 0x0187. It replaces only the 2-bit attenuation field in bits 7:6 and then clears the standard status register.

Top module: `ext_reg_sequencer`

## Requirements
- R1: An extended write (cmd_op 2'b01) issues four standard writes, in this order: cmd_xdata to 0x1B, cmd_xaddr[15:8] to 0x1C, cmd_xaddr[7:0] to 0x1D, and 0x02 to the control register 0x1E.
- R2: An extended read (cmd_op 2'b00) issues three standard writes: the high address byte to 0x1C, the low address byte to 0x1D, and 0x01 to 0x1E. After completion it reads 0x1B, and that byte appears on rd_data with a success code.
- R3: After the control write, the block reads 0x1E. The access counts as complete on the first such read that returns 0x00.
- R4: There are at most MAX_POLLS reads of 0x1E per extended access, with exactly POLL_GAP request-free cycles between two consecutive reads. If the last allowed read is still non-zero, the command ends with err_code 2 (timeout) and no further access.
- R5: Sensitivity update (cmd_op[1] = 1) does an extended read of 0x0187 and then an extended write of 0x0187. The written value keeps bits 5:0 of the value read and sets bits 7:6 to cmd_level: levels 1 to 4 are codes 0 to 3, giving 0x00, 0x40, 0x80 or 0xC0. The value written is reported on rd_data.
- R6: Once the sensitivity write has completed, the block writes 0x00 to status register 0x02. Only after that write does it signal done with err_code 0.
- R7: A standard access acknowledged with bus_err ends the command at once: done pulses with err_code 1 and no further access is issued.
- R8: If bus_err arrives on the final allowed poll read, the code is bus error (1), not timeout.
- R9: cmd_ready is high exactly when the block is idle, which includes the cycle in which done pulses. done lasts one cycle. A command waiting in that cycle is accepted at the next edge.
- R10: While bus_req is high and bus_ack is low, bus_addr, bus_we and bus_wdata stay unchanged.
- R11: After reset: cmd_ready = 1, bus_req = 0, done = 0 and err_code = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken at the next edge |
| cmd_op | input | 2 | 00 extended read, 01 extended write, 1x sensitivity update |
| cmd_xaddr | input | 16 | Extended address (ignored for sensitivity update) |
| cmd_xdata | input | 8 | Byte to write for an extended write |
| cmd_level | input | 2 | Attenuation code for sensitivity update |
| done | output | 1 | One-cycle end-of-command strobe |
| err_code | output | 2 | 0 success, 1 bus error, 2 timeout; valid with done |
| rd_data | output | 8 | Byte read, or byte written by sensitivity update |
| bus_req | output | 1 | Standard register access request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | 5 | Standard register address |
| bus_wdata | output | 8 | Write byte |
| bus_ack | input | 1 | Access accepted this cycle |
| bus_rdata | input | 8 | Read byte, valid with bus_ack |
| bus_err | input | 1 | Access failed, valid with bus_ack |

## Verification
Two pairs of events can land in the same cycle. The first pair is the timeout decision and a transport error. The bench keeps the control register busy for all MAX_POLLS reads and injects bus_err on exactly the last of them, and it expects code 1 rather than 2. The second pair is a done pulse and the next command. The bench holds a second command valid while the first is still running and checks that it is taken in the done cycle: its write sequence must follow directly, and both results must arrive intact.

// File: rtl/era_pkg.sv
package era_pkg;
    localparam int REG_AW = 5;
    localparam int DW     = 8;
    localparam int XAW    = 16;

    localparam logic [REG_AW-1:0] REG_STATUS = 5'h02;
    localparam logic [REG_AW-1:0] REG_XVAL   = 5'h1B;
    localparam logic [REG_AW-1:0] REG_XHI    = 5'h1C;
    localparam logic [REG_AW-1:0] REG_XLO    = 5'h1D;
    localparam logic [REG_AW-1:0] REG_XCTL   = 5'h1E;

    localparam logic [DW-1:0] XCTL_RD = 8'h01;
    localparam logic [DW-1:0] XCTL_WR = 8'h02;

    localparam logic [XAW-1:0] XADDR_SENSE = 16'h0187;
    localparam int ATT_LSB = 6;
    localparam int ATT_W   = 2;

    typedef enum logic [1:0] {
        OP_XRD   = 2'b00,
        OP_XWR   = 2'b01,
        OP_SENSE = 2'b10
    } op_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_BUS     = 2'd1,
        ERR_TIMEOUT = 2'd2
    } errc_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SEQ,
        PH_POLL,
        PH_GAP,
        PH_FETCH,
        PH_CLEAR
    } phase_e;
endpackage

// File: rtl/era_step_map.sv
module era_step_map
    import era_pkg::*;
(
    input  logic              wr_mode,
    input  logic [1:0]        step,
    input  logic [XAW-1:0]    xaddr,
    input  logic [DW-1:0]     xval,
    output logic [REG_AW-1:0] reg_addr,
    output logic [DW-1:0]     reg_data
);
    // Step order is behaviour: value, high address, low address, control.
    always_comb begin
        unique case (step)
            2'd0: begin
                reg_addr = REG_XVAL;
                reg_data = xval;
            end
            2'd1: begin
                reg_addr = REG_XHI;
                reg_data = xaddr[XAW-1 -: DW];
            end
            2'd2: begin
                reg_addr = REG_XLO;
                reg_data = xaddr[DW-1:0];
            end
            default: begin
                reg_addr = REG_XCTL;
                reg_data = wr_mode ? XCTL_WR : XCTL_RD;
            end
        endcase
    end
endmodule

// File: rtl/era_gap_timer.sv
module era_gap_timer #(
    parameter int GAP = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expire
);
    localparam int CW = $clog2(GAP + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CW'(GAP);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = (cnt_q == CW'(1));
endmodule

// File: rtl/era_atten_merge.sv
module era_atten_merge
    import era_pkg::*;
(
    input  logic [DW-1:0]    cur,
    input  logic [ATT_W-1:0] lvl,
    output logic [DW-1:0]    merged
);
    localparam logic [DW-1:0] FMASK = DW'(((1 << ATT_W) - 1) << ATT_LSB);

    always_comb begin
        merged = (cur & ~FMASK) | (DW'(lvl) << ATT_LSB);
    end
endmodule

// File: rtl/ext_reg_sequencer.sv
module ext_reg_sequencer
    import era_pkg::*;
#(
    parameter int MAX_POLLS = 5,
    parameter int POLL_GAP  = 1_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [XAW-1:0]    cmd_xaddr,
    input  logic [DW-1:0]     cmd_xdata,
    input  logic [ATT_W-1:0]  cmd_level,
    output logic              done,
    output logic [1:0]        err_code,
    output logic [DW-1:0]     rd_data,
    output logic              bus_req,
    output logic              bus_we,
    output logic [REG_AW-1:0] bus_addr,
    output logic [DW-1:0]     bus_wdata,
    input  logic              bus_ack,
    input  logic [DW-1:0]     bus_rdata,
    input  logic              bus_err
);
    localparam int PCW = $clog2(MAX_POLLS + 1);

    typedef struct packed {
        phase_e           phase;
        logic             sense;
        logic             wr_stage;
        logic [1:0]       step;
        logic [PCW-1:0]   polls;
        logic [XAW-1:0]   xaddr;
        logic [DW-1:0]    xval;
        logic [ATT_W-1:0] lvl;
        logic             done;
        errc_e            err;
        logic [DW-1:0]    rdata;
    } st_t;

    st_t s_d, s_q;

    logic [REG_AW-1:0] map_addr;
    logic [DW-1:0]     map_data;
    logic [DW-1:0]     merged;
    logic              gap_start;
    logic              gap_expire;
    logic              xfer;

    era_step_map u_map (
        .wr_mode  (s_q.wr_stage),
        .step     (s_q.step),
        .xaddr    (s_q.xaddr),
        .xval     (s_q.xval),
        .reg_addr (map_addr),
        .reg_data (map_data)
    );

    era_atten_merge u_merge (
        .cur    (bus_rdata),
        .lvl    (s_q.lvl),
        .merged (merged)
    );

    era_gap_timer #(.GAP(POLL_GAP)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (gap_start),
        .expire (gap_expire)
    );

    // Standard-register request derived from the registered phase only.
    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = REG_XCTL;
        bus_wdata = '0;
        unique case (s_q.phase)
            PH_SEQ: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = map_addr;
                bus_wdata = map_data;
            end
            PH_POLL: begin
                bus_req  = 1'b1;
                bus_addr = REG_XCTL;
            end
            PH_FETCH: begin
                bus_req  = 1'b1;
                bus_addr = REG_XVAL;
            end
            PH_CLEAR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = REG_STATUS;
                bus_wdata = '0;
            end
            default: ;
        endcase
    end

    assign xfer = bus_req & bus_ack;

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        gap_start = 1'b0;

        unique case (s_q.phase)
            PH_IDLE: begin
                if (cmd_valid) begin
                    s_d.sense    = cmd_op[1];
                    s_d.lvl      = cmd_level;
                    s_d.xval     = cmd_xdata;
                    s_d.xaddr    = cmd_op[1] ? XADDR_SENSE : cmd_xaddr;
                    s_d.wr_stage = (cmd_op == OP_XWR);
                    s_d.step     = (cmd_op == OP_XWR) ? 2'd0 : 2'd1;
                    s_d.phase    = PH_SEQ;
                end
            end
            PH_SEQ: begin
                if (xfer && !bus_err) begin
                    if (s_q.step == 2'd3) begin
                        s_d.phase = PH_POLL;
                        s_d.polls = '0;
                    end else begin
                        s_d.step = s_q.step + 2'd1;
                    end
                end
            end
            PH_POLL: begin
                if (xfer && !bus_err) begin
                    s_d.polls = s_q.polls + 1'b1;
                    if (bus_rdata == '0) begin
                        if (!s_q.wr_stage) begin
                            s_d.phase = PH_FETCH;
                        end else if (s_q.sense) begin
                            s_d.phase = PH_CLEAR;
                        end else begin
                            s_d.phase = PH_IDLE;
                            s_d.done  = 1'b1;
                            s_d.err   = ERR_NONE;
                        end
                    end else if (s_q.polls == PCW'(MAX_POLLS - 1)) begin
                        s_d.phase = PH_IDLE;
                        s_d.done  = 1'b1;
                        s_d.err   = ERR_TIMEOUT;
                    end else begin
                        s_d.phase = PH_GAP;
                        gap_start = 1'b1;
                    end
                end
            end
            PH_GAP: begin
                if (gap_expire) s_d.phase = PH_POLL;
            end
            PH_FETCH: begin
                if (xfer && !bus_err) begin
                    if (s_q.sense) begin
                        s_d.xval     = merged;
                        s_d.rdata    = merged;
                        s_d.wr_stage = 1'b1;
                        s_d.step     = 2'd0;
                        s_d.phase    = PH_SEQ;
                    end else begin
                        s_d.rdata = bus_rdata;
                        s_d.phase = PH_IDLE;
                        s_d.done  = 1'b1;
                        s_d.err   = ERR_NONE;
                    end
                end
            end
            PH_CLEAR: begin
                if (xfer && !bus_err) begin
                    s_d.phase = PH_IDLE;
                    s_d.done  = 1'b1;
                    s_d.err   = ERR_NONE;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase

        // A failed sub-access wins over every other outcome, including timeout.
        if (xfer && bus_err) begin
            s_d.phase = PH_IDLE;
            s_d.done  = 1'b1;
            s_d.err   = ERR_BUS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cmd_ready = (s_q.phase == PH_IDLE);
    assign done      = s_q.done;
    assign err_code  = s_q.err;
    assign rd_data   = s_q.rdata;

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_ready_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !bus_req);

    assert_err_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && bus_err) |=> (!bus_req && done && err_code == ERR_BUS));

    assert_poll_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_addr == REG_XCTL) |-> (s_q.polls < PCW'(MAX_POLLS)));

    assert_timeout_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && !bus_err && !bus_we && bus_addr == REG_XCTL && bus_rdata == '0)
        |=> !(done && err_code == ERR_TIMEOUT));
endmodule

// File: tb/ext_reg_sequencer_test.sv
module ext_reg_sequencer_test;
    import era_pkg::*;

    localparam int MAXP = 5;
    localparam int GAP  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic       cmd_valid, cmd_ready;
    logic [1:0] cmd_op;
    logic [15:0] cmd_xaddr;
    logic [7:0] cmd_xdata;
    logic [1:0] cmd_level;
    logic       done;
    logic [1:0] err_code;
    logic [7:0] rd_data;
    logic       bus_req, bus_we;
    logic [4:0] bus_addr;
    logic [7:0] bus_wdata;
    logic       bus_ack;
    logic [7:0] bus_rdata;
    logic       bus_err;

    ext_reg_sequencer #(.MAX_POLLS(MAXP), .POLL_GAP(GAP)) uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_xaddr(cmd_xaddr), .cmd_xdata(cmd_xdata), .cmd_level(cmd_level),
        .done(done), .err_code(err_code), .rd_data(rd_data),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_err(bus_err)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    typedef struct {
        bit         we;
        logic [4:0] a;
        logic [7:0] d;
        string      r;
    } acc_t;

    typedef struct {
        int    err;
        int    rd;
        bit    chk_rd;
        string r;
    } res_t;

    acc_t exp_q[$];
    res_t res_q[$];
    acc_t bld_q[$];
    int   bld_out;

    // ---------------- device model behind the transport ----------------
    logic [7:0] xmem [int];
    logic [7:0] t_val = 8'h00, t_hi = 8'h00, t_lo = 8'h00, ctl_cur = 8'h00;
    int ctl_left = 0;
    int busy_cfg = 0, lat_cfg = 0, err_abs = 0, glob = 0, wcnt = 0, idle = 0;
    bit last_poll = 1'b0;
    logic [13:0] snap;

    task automatic capture();
        acc_t e;
        int key;
        glob++;
        if (exp_q.size() == 0) begin
            check(1'b0, "R7", "access with none expected", {bus_we, bus_addr, bus_wdata}, 0);
        end else begin
            e = exp_q.pop_front();
            check(e.we == bus_we && e.a == bus_addr && (!e.we || e.d == bus_wdata), e.r,
                  "access {we,addr,data}", {bus_we, bus_addr, bus_wdata}, {e.we, e.a, e.d});
        end
        if (!bus_we && bus_addr == REG_XCTL) begin
            if (last_poll) check(idle == GAP, "R4", "idle cycles between polls", idle, GAP);
            last_poll = 1'b1;
        end else begin
            last_poll = 1'b0;
        end
        idle = 0;
        key = int'({t_hi, t_lo});
        bus_rdata = 8'h00;
        if (glob == err_abs) begin
            bus_err   = 1'b1;
            bus_rdata = 8'hEE;
        end else if (bus_we) begin
            case (bus_addr)
                REG_XVAL: t_val = bus_wdata;
                REG_XHI:  t_hi = bus_wdata;
                REG_XLO:  t_lo = bus_wdata;
                REG_XCTL: begin
                    key = int'({t_hi, t_lo});
                    ctl_left = busy_cfg;
                    ctl_cur  = bus_wdata;
                    if (bus_wdata == 8'h01) t_val = xmem.exists(key) ? xmem[key] : 8'h00;
                    else if (bus_wdata == 8'h02) xmem[key] = t_val;
                end
                default: ;
            endcase
        end else begin
            case (bus_addr)
                REG_XVAL: bus_rdata = t_val;
                REG_XCTL: begin
                    if (ctl_left > 0) begin
                        bus_rdata = ctl_cur;
                        ctl_left--;
                    end
                end
                default: ;
            endcase
        end
        bus_ack = 1'b1;
    endtask

    initial begin
        bus_ack = 1'b0;
        bus_rdata = 8'h00;
        bus_err = 1'b0;
        forever begin
            @(negedge clk);
            bus_ack = 1'b0;
            bus_err = 1'b0;
            if (rst_n) begin
                if (!bus_req) begin
                    idle++;
                    wcnt = 0;
                end else if (wcnt < lat_cfg) begin
                    if (wcnt == 0) snap = {bus_we, bus_addr, bus_wdata};
                    else check(snap == {bus_we, bus_addr, bus_wdata}, "R10",
                               "request held while unacknowledged", {bus_we, bus_addr, bus_wdata}, snap);
                    wcnt++;
                end else begin
                    wcnt = 0;
                    capture();
                end
            end
        end
    end

    // ---------------- result monitor, every clock ----------------
    initial begin
        res_t e;
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                check(cmd_ready == 1'b1, "R9", "cmd_ready in done cycle", cmd_ready, 1);
                if (res_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected done", err_code, 0);
                end else begin
                    e = res_q.pop_front();
                    check(err_code == e.err, e.r, "err_code", err_code, e.err);
                    if (e.chk_rd && e.err == 0) check(rd_data == e.rd, e.r, "rd_data", rd_data, e.rd);
                end
            end
        end
    end

    // ---------------- expected-sequence builders ----------------
    function automatic void push_acc(bit we, logic [4:0] a, logic [7:0] d, string r);
        acc_t x;
        x.we = we; x.a = a; x.d = d; x.r = r;
        bld_q.push_back(x);
    endfunction

    function automatic void ext_access(bit wr, logic [15:0] xa, logic [7:0] v, int busy, string r);
        int n;
        if (wr) push_acc(1'b1, REG_XVAL, v, r);
        push_acc(1'b1, REG_XHI, xa[15:8], r);
        push_acc(1'b1, REG_XLO, xa[7:0], r);
        push_acc(1'b1, REG_XCTL, wr ? 8'h02 : 8'h01, r);
        n = (busy >= MAXP) ? MAXP : busy + 1;
        for (int i = 0; i < n; i++) push_acc(1'b0, REG_XCTL, 8'h00, "R3");
        if (busy >= MAXP) bld_out = 2;
    endfunction

    task automatic issue(input logic [1:0] op, input logic [15:0] xa, input logic [7:0] xd,
                         input logic [1:0] lvl, input logic [7:0] oldv, input int busy,
                         input int errk, input int lat, input string r);
        res_t res;
        logic [7:0] mrg;
        bld_q.delete();
        bld_out = 0;
        res.chk_rd = 1'b0;
        res.rd = 0;
        mrg = (oldv & 8'h3F) | ({6'd0, lvl} << 6);
        if (op == 2'b01) begin
            ext_access(1'b1, xa, xd, busy, r);
        end else if (op == 2'b00) begin
            ext_access(1'b0, xa, 8'h00, busy, r);
            if (bld_out == 0) push_acc(1'b0, REG_XVAL, 8'h00, "R2");
            res.chk_rd = 1'b1;
            res.rd = oldv;
        end else begin
            ext_access(1'b0, XADDR_SENSE, 8'h00, busy, "R5");
            if (bld_out == 0) begin
                push_acc(1'b0, REG_XVAL, 8'h00, "R5");
                ext_access(1'b1, XADDR_SENSE, mrg, busy, "R5");
                if (bld_out == 0) push_acc(1'b1, REG_STATUS, 8'h00, "R6");
            end
            res.chk_rd = 1'b1;
            res.rd = mrg;
        end
        if (errk > 0 && errk <= bld_q.size()) begin
            while (bld_q.size() > errk) void'(bld_q.pop_back());
            bld_out = 1;
            err_abs = glob + errk;
        end else begin
            err_abs = 0;
        end
        res.err = bld_out;
        res.r = r;
        busy_cfg = busy;
        lat_cfg = lat;
        foreach (bld_q[i]) exp_q.push_back(bld_q[i]);
        res_q.push_back(res);
        cmd_op = op; cmd_xaddr = xa; cmd_xdata = xd; cmd_level = lvl;
        cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic finish_all(input string r);
        while (res_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, r, "expected accesses left over", exp_q.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        cmd_valid = 1'b0; cmd_op = 2'b00; cmd_xaddr = 16'h0; cmd_xdata = 8'h0; cmd_level = 2'd0;
        xmem[int'(16'hBEEF)] = 8'h3C;
        xmem[int'(16'h0187)] = 8'h5A;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready == 1'b1, "R11", "cmd_ready after reset", cmd_ready, 1);
        check(bus_req == 1'b0, "R11", "bus_req after reset", bus_req, 0);
        check(done == 1'b0, "R11", "done after reset", done, 0);
        check(err_code == 2'd0, "R11", "err_code after reset", err_code, 0);

        // R1 plain extended write, immediate completion
        issue(2'b01, 16'h1234, 8'hA5, 2'd0, 8'h00, 0, 0, 0, "R1");
        finish_all("R1");
        // R2 extended read with slow transport and two busy polls
        issue(2'b00, 16'h1234, 8'h00, 2'd0, 8'hA5, 2, 0, 2, "R2");
        finish_all("R2");
        // R3 completion on the last allowed poll
        issue(2'b00, 16'hBEEF, 8'h00, 2'd0, 8'h3C, MAXP - 1, 0, 0, "R3");
        finish_all("R3");
        // R4 timeout after all polls busy
        issue(2'b01, 16'h2222, 8'h11, 2'd0, 8'h00, MAXP, 0, 0, "R4");
        finish_all("R4");
        // R5/R6 sensitivity updates at several levels
        issue(2'b10, 16'h0000, 8'h00, 2'd2, 8'h5A, 1, 0, 0, "R5");
        finish_all("R6");
        issue(2'b00, 16'h0187, 8'h00, 2'd0, 8'h9A, 0, 0, 0, "R5");
        finish_all("R5");
        issue(2'b11, 16'hFFFF, 8'h00, 2'd3, 8'h9A, 0, 0, 1, "R5");
        finish_all("R5");
        issue(2'b10, 16'h0000, 8'h00, 2'd0, 8'hDA, 0, 0, 0, "R5");
        finish_all("R6");
        // R7 error on second write aborts the sequence
        issue(2'b01, 16'h4444, 8'h22, 2'd0, 8'h00, 0, 2, 0, "R7");
        finish_all("R7");
        // R8 error on final poll beats timeout
        issue(2'b01, 16'h5555, 8'h33, 2'd0, 8'h00, MAXP, 4 + MAXP, 0, "R8");
        finish_all("R8");
        // R7 error on the status clear of a sensitivity update
        issue(2'b10, 16'h0000, 8'h00, 2'd1, 8'h1A, 0, 11, 0, "R7");
        finish_all("R7");
        // R9 back-to-back: second command waits and is taken in the done cycle
        issue(2'b01, 16'h3333, 8'h77, 2'd0, 8'h00, 1, 0, 0, "R9");
        issue(2'b00, 16'h3333, 8'h00, 2'd0, 8'h77, 1, 0, 0, "R9");
        finish_all("R9");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule